// File: doc/BRIEF.md
# Three-Wire-Plus-Select Serial EEPROM Command Master

This block sits on the host side of a four-pin serial EEPROM link: select, serial clock, serial data toward the memory and serial data back from it. A request port takes one command together with a word address, a word count and write data. The block expands the request into complete serial frames. Each frame is a start bit, a two-bit opcode and an address sent most significant bit first. A write frame adds sixteen data bits. A read frame clocks in a dummy zero followed by sixteen data bits. Read words come back one at a time with a one-cycle valid strobe, and a done pulse closes each request.

Programming commands are wrapped in a write-enable frame before and a write-disable frame after. After each programming frame the block drops select for one serial slot, raises it again and keeps clocking until the memory drives its data line high. A limit on these poll slots raises an error flag if the memory never reports ready. The address width (6 or 8 bits) is a parameter. The low and high times of the serial clock are counted in system clock cycles and are taken from inputs when a request is accepted.

Top module: `uw_eeprom_master`

## Requirements
- R1: Every frame is a start bit 1, a two-bit opcode and an ADDR_W-bit field, all sent MSB first. The opcodes are read 10, write 01, erase 11 and extended 00.
- R2: Extended frames put a two-bit code in the top of the address field and zeros below it: enable 11, disable 00, erase-all 10, write-all 01.
- R3: A read frame is followed by 17 receive slots with do_o low. The first sampled bit is dropped and the other 16 form the word, MSB first. rd_valid_o is high for one cycle with rd_data_o, in the first cycle after the last receive slot.
- R4: The write and write-all frames carry 16 data bits MSB first, right after the address field. req_wdata_i is sampled when such a frame is loaded, and wdata_ack_o is high in that frame's first cycle.
- R5: Write, erase, erase-all and write-all requests are preceded by an enable frame and followed by a disable frame, each of which is followed by its own gap slot.
- R6: After a programming frame come one gap slot, then poll slots with select high and do_o low, until di_i samples 1. Then one more gap slot.
- R7: If di_i samples 0 in poll_limit_i poll slots in a row (0 counts as 1), polling ends and err_o is set. The remaining words are skipped and the disable frame is still sent. err_o holds until the next request is accepted.
- R8: Every frame is followed by at least one full serial slot with select low.
- R9: A serial slot is sck_lo_i cycles low followed by sck_hi_i cycles high (0 counts as 1), latched at accept. do_o and cs_o change only where sck_o falls, and di_i is sampled at the end of the last low cycle.
- R10: Read, write and erase repeat for req_count_i words (0 counts as 1). Each word has its own full frame, and the address steps by one modulo 2^ADDR_W. The other commands run once.
- R11: req_ready_o is high only while idle. done_o is high for one cycle, in the first cycle after the last gap slot.
- R12: After reset: cs_o, sck_o, do_o, done_o and rd_valid_o are 0 and req_ready_o is 1.
- R13: The req_cmd_i codes are 0 read, 1 write, 2 enable, 3 disable, 4 erase, 5 erase-all and 6 write-all. Code 7 behaves exactly as disable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Idle, request accepted this cycle if valid |
| req_cmd_i | input | 3 | Command code |
| req_addr_i | input | ADDR_W | First word address |
| req_count_i | input | CNT_W | Number of words |
| req_wdata_i | input | 16 | Write data for the current word |
| wdata_ack_o | output | 1 | Current write word taken |
| sck_lo_i | input | DIV_W | Serial clock low time in cycles |
| sck_hi_i | input | DIV_W | Serial clock high time in cycles |
| poll_limit_i | input | POLL_W | Poll slots before timeout |
| rd_data_o | output | 16 | Read word |
| rd_valid_o | output | 1 | Read word strobe |
| done_o | output | 1 | Request finished |
| err_o | output | 1 | Ready poll timed out |
| cs_o | output | 1 | Memory select |
| sck_o | output | 1 | Serial clock |
| do_o | output | 1 | Serial data to memory |
| di_i | input | 1 | Serial data from memory |

## Verification
The bench builds an expected cycle-by-cycle pin picture from each request and drives di_i from the same picture. Each command code is tried in turn, so a wrong opcode bit, a wrong extended code or a missing data field shows up on a specific slot. Reads use distinct word patterns, a count that wraps past the top address and a zero count, which separates dummy-bit handling, address stepping and count defaulting. Writes are run once with a memory that becomes ready and once with one that never does, which tells the poll exit apart from the timeout path and its skip to the disable frame. Several low/high time pairs, including zero, check the slot shape.

// File: rtl/uw_pkg.sv
package uw_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_WEN   = 3'd2,
    OP_WDS   = 3'd3,
    OP_ERASE = 3'd4,
    OP_ERAL  = 3'd5,
    OP_WRAL  = 3'd6,
    OP_RSVD  = 3'd7
  } uw_op_e;

  typedef enum logic [2:0] {ST_IDLE, ST_SEND, ST_RECV, ST_GAP, ST_POLL} uw_state_e;
  typedef enum logic [1:0] {STG_EN, STG_MAIN, STG_DIS} uw_stage_e;

  function automatic logic op_prog(uw_op_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL};
  endfunction

  function automatic logic op_data(uw_op_e op);
    return op inside {OP_WRITE, OP_WRAL};
  endfunction

  function automatic logic op_multi(uw_op_e op);
    return op inside {OP_READ, OP_WRITE, OP_ERASE};
  endfunction
endpackage

// File: rtl/uw_slot_timer.sv
module uw_slot_timer #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] lo_i,
  input  logic [DIV_W-1:0] hi_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             end_o
);
  logic             ph_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] lim;
  logic             last;

  assign lim    = ph_q ? hi_i : lo_i;
  assign last   = (lim == '0) || (cnt_q == lim - DIV_W'(1));
  assign sck_o  = ph_q;
  assign rise_o = run_i && !ph_q && last;
  assign end_o  = run_i && ph_q && last;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (!run_i) begin
      ph_q  <= 1'b0;
      cnt_q <= '0;
    end else if (last) begin
      ph_q  <= !ph_q;
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end

  a_r9_rise_then_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> sck_o);
  a_r9_end_then_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_o |=> !sck_o);
endmodule

// File: rtl/uw_frame_build.sv
module uw_frame_build import uw_pkg::*; #(
  parameter int ADDR_W = 6,
  localparam int FW = 3 + ADDR_W + WORD_W,
  localparam int LW = $clog2(FW + 1)
) (
  input  uw_op_e            op_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WORD_W-1:0] data_i,
  output logic [FW-1:0]     frame_o,
  output logic [LW-1:0]     len_o
);
  logic [1:0]        opc;
  logic [ADDR_W-1:0] fld;
  logic [1:0]        ext;

  always_comb begin
    opc = 2'b00;
    ext = 2'b00;
    fld = addr_i;
    unique case (op_i)
      OP_READ:  opc = 2'b10;
      OP_WRITE: opc = 2'b01;
      OP_ERASE: opc = 2'b11;
      OP_WEN:   ext = 2'b11;
      OP_ERAL:  ext = 2'b10;
      OP_WRAL:  ext = 2'b01;
      default:  ext = 2'b00;
    endcase
    if (opc == 2'b00) fld = {ext, {(ADDR_W-2){1'b0}}};
  end

  assign frame_o = {1'b1, opc, fld, op_data(op_i) ? data_i : {WORD_W{1'b0}}};
  assign len_o   = LW'(3 + ADDR_W) + (op_data(op_i) ? LW'(WORD_W) : LW'(0));
endmodule

// File: rtl/uw_eeprom_master.sv
module uw_eeprom_master import uw_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int CNT_W  = 8,
  parameter int DIV_W  = 8,
  parameter int POLL_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [2:0]        req_cmd_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_count_i,
  input  logic [WORD_W-1:0] req_wdata_i,
  output logic              wdata_ack_o,
  input  logic [DIV_W-1:0]  sck_lo_i,
  input  logic [DIV_W-1:0]  sck_hi_i,
  input  logic [POLL_W-1:0] poll_limit_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              rd_valid_o,
  output logic              done_o,
  output logic              err_o,
  output logic              cs_o,
  output logic              sck_o,
  output logic              do_o,
  input  logic              di_i
);
  localparam int FW = 3 + ADDR_W + WORD_W;
  localparam int LW = $clog2(FW + 1);

  uw_state_e         st_q;
  uw_stage_e         stg_q;
  uw_op_e            cmd_q, req_op, ld_op;
  logic [ADDR_W-1:0] addr_q, ld_addr;
  logic [CNT_W-1:0]  left_q;
  logic              polled_q, pend_q, err_q;
  logic [FW-1:0]     sh_q, fb_frame;
  logic [LW-1:0]     bits_q, fb_len;
  logic [WORD_W-1:0] rx_q, rdata_q;
  logic [DIV_W-1:0]  lo_q, hi_q;
  logic [POLL_W-1:0] plim_q, pcnt_q;
  logic [POLL_W:0]   pnext;
  logic              done_q, rv_q, ack_q;
  logic              run, rise, slot_end, more;

  assign req_op = uw_op_e'(req_cmd_i);
  assign run    = (st_q != ST_IDLE);
  assign more   = op_multi(cmd_q) && (left_q > CNT_W'(1)) && !err_q;
  assign pnext  = {1'b0, pcnt_q} + {{POLL_W{1'b0}}, 1'b1};

  uw_slot_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk_i, .rst_ni, .run_i(run), .lo_i(lo_q), .hi_i(hi_q),
    .sck_o, .rise_o(rise), .end_o(slot_end)
  );

  // next frame to load: first frame on accept, otherwise decided at gap end
  always_comb begin
    ld_op   = cmd_q;
    ld_addr = addr_q;
    if (st_q == ST_IDLE) begin
      ld_op   = op_prog(req_op) ? OP_WEN : req_op;
      ld_addr = req_addr_i;
    end else if (stg_q == STG_MAIN && !(op_prog(cmd_q) && !polled_q)) begin
      if (more) ld_addr = addr_q + ADDR_W'(1);
      else      ld_op   = OP_WDS;
    end
  end

  uw_frame_build #(.ADDR_W(ADDR_W)) u_fb (
    .op_i(ld_op), .addr_i(ld_addr), .data_i(req_wdata_i),
    .frame_o(fb_frame), .len_o(fb_len)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= ST_IDLE;   stg_q <= STG_MAIN;  cmd_q <= OP_READ;
      addr_q <= '0;      left_q <= '0;       polled_q <= 1'b0;
      pend_q <= 1'b0;    err_q <= 1'b0;      sh_q <= '0;
      bits_q <= '0;      rx_q <= '0;         rdata_q <= '0;
      lo_q <= '0;        hi_q <= '0;         plim_q <= '0;
      pcnt_q <= '0;      done_q <= 1'b0;     rv_q <= 1'b0;
      ack_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      rv_q   <= 1'b0;
      ack_q  <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid_i) begin
          cmd_q    <= req_op;
          addr_q   <= req_addr_i;
          left_q   <= (req_count_i == '0) ? CNT_W'(1) : req_count_i;
          lo_q     <= sck_lo_i;
          hi_q     <= sck_hi_i;
          plim_q   <= poll_limit_i;
          err_q    <= 1'b0;
          polled_q <= 1'b0;
          stg_q    <= op_prog(req_op) ? STG_EN : STG_MAIN;
          sh_q     <= fb_frame;
          bits_q   <= fb_len;
          st_q     <= ST_SEND;
        end
        ST_SEND: if (slot_end) begin
          if (bits_q == LW'(1)) begin
            if (stg_q == STG_MAIN && cmd_q == OP_READ) begin
              st_q   <= ST_RECV;
              bits_q <= LW'(WORD_W + 1);
            end else begin
              st_q <= ST_GAP;
            end
          end else begin
            sh_q   <= sh_q << 1;
            bits_q <= bits_q - LW'(1);
          end
        end
        ST_RECV: begin
          if (rise) begin
            rx_q   <= {rx_q[WORD_W-2:0], di_i};
            bits_q <= bits_q - LW'(1);
          end
          if (slot_end && bits_q == '0) begin
            st_q    <= ST_GAP;
            rv_q    <= 1'b1;
            rdata_q <= rx_q;
          end
        end
        ST_POLL: begin
          if (rise) begin
            if (di_i) begin
              pend_q <= 1'b1;
            end else begin
              pcnt_q <= pnext[POLL_W-1:0];
              if (pnext >= {1'b0, plim_q}) begin
                pend_q <= 1'b1;
                err_q  <= 1'b1;
              end
            end
          end
          if (slot_end && pend_q) begin
            st_q     <= ST_GAP;
            polled_q <= 1'b1;
          end
        end
        ST_GAP: if (slot_end) begin
          if (stg_q == STG_MAIN && op_prog(cmd_q) && !polled_q) begin
            st_q   <= ST_POLL;
            pend_q <= 1'b0;
            pcnt_q <= '0;
          end else if (stg_q == STG_DIS || (stg_q == STG_MAIN && !more && !op_prog(cmd_q))) begin
            st_q   <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            if (stg_q == STG_EN) begin
              stg_q <= STG_MAIN;
            end else if (more) begin
              addr_q   <= addr_q + ADDR_W'(1);
              left_q   <= left_q - CNT_W'(1);
              polled_q <= 1'b0;
            end else begin
              stg_q <= STG_DIS;
            end
            sh_q   <= fb_frame;
            bits_q <= fb_len;
            ack_q  <= op_data(ld_op);
            st_q   <= ST_SEND;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o = (st_q == ST_IDLE);
  assign cs_o        = st_q inside {ST_SEND, ST_RECV, ST_POLL};
  assign do_o        = (st_q == ST_SEND) && sh_q[FW-1];
  assign rd_data_o   = rdata_q;
  assign rd_valid_o  = rv_q;
  assign done_o      = done_q;
  assign err_o       = err_q;
  assign wdata_ack_o = ack_q;

  a_r9_pins_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_o |-> ($stable(do_o) && $stable(cs_o)));
  a_r11_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> (!cs_o && !sck_o));
  a_r11_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r3_valid_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |=> !rd_valid_o);
  a_r8_gap_min: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |=> !cs_o);
  a_r7_err_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(err_o) |-> $past(req_valid_i && req_ready_o));
endmodule

// File: tb/tb_uw_eeprom_master.sv
module tb_uw_eeprom_master;
  localparam int AW = 6;

  typedef struct packed {
    logic cs; logic sck; logic dout; logic din; logic rv;
    logic ack; logic done; logic rdy; logic err; logic [15:0] rdata;
  } cyc_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, di = 1'b0;
  logic [2:0] req_cmd = '0;
  logic [AW-1:0] req_addr = '0;
  logic [7:0] req_count = '0;
  logic [15:0] req_wdata = '0;
  logic [7:0] sck_lo = 8'd1, sck_hi = 8'd1;
  logic [15:0] poll_limit = '0;
  logic req_ready, wdata_ack, rd_valid, done, err, cs, sck, dout;
  logic [15:0] rd_data;

  cyc_t exp_q[$];
  logic [15:0] wq[$];
  logic [15:0] mem [64];
  int n_chk = 0, n_fail = 0, widx = 0, lo_e = 1, hi_e = 1;
  bit chk_on = 1'b0;
  string cur_tag = "R12";

  uw_eeprom_master #(.ADDR_W(AW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_cmd_i(req_cmd), .req_addr_i(req_addr), .req_count_i(req_count),
    .req_wdata_i(req_wdata), .wdata_ack_o(wdata_ack), .sck_lo_i(sck_lo),
    .sck_hi_i(sck_hi), .poll_limit_i(poll_limit), .rd_data_o(rd_data),
    .rd_valid_o(rd_valid), .done_o(done), .err_o(err), .cs_o(cs), .sck_o(sck),
    .do_o(dout), .di_i(di)
  );

  always #5 clk = ~clk;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // per-cycle comparison against the expected pin picture
  always @(negedge clk) if (chk_on) begin
    cyc_t e;
    if (exp_q.size() > 0) e = exp_q.pop_front();
    else begin e = '0; e.rdy = 1'b1; end
    di = e.din;
    chk(cs === e.cs, cur_tag, "cs", cs, e.cs);
    chk(dout === e.dout, cur_tag, "do", dout, e.dout);
    chk(sck === e.sck, "R9", "sck", sck, e.sck);
    chk(rd_valid === e.rv, "R3", "rd_valid", rd_valid, e.rv);
    if (e.rv) chk(rd_data === e.rdata, "R3", "rd_data", rd_data, e.rdata);
    chk(wdata_ack === e.ack, "R4", "wdata_ack", wdata_ack, e.ack);
    chk(done === e.done, "R11", "done", done, e.done);
    chk(req_ready === e.rdy, "R11", "ready", req_ready, e.rdy);
    if (e.done) chk(err === e.err, "R7", "err", err, e.err);
    if (e.ack) begin
      widx++;
      if (widx < wq.size()) req_wdata = wq[widx];
    end
  end

  task automatic slot(bit c, bit d, bit dn, bit rv, logic [15:0] rd, bit ack);
    for (int i = 0; i < lo_e + hi_e; i++) begin
      cyc_t e = '0;
      e.cs = c; e.sck = (i >= lo_e); e.dout = d; e.din = dn;
      if (i == 0) begin e.rv = rv; e.rdata = rd; e.ack = ack; end
      exp_q.push_back(e);
    end
  endtask

  task automatic gap(bit rv, logic [15:0] rd);
    slot(1'b0, 1'b0, 1'b0, rv, rd, 1'b0);
  endtask

  task automatic frame(logic [1:0] opc, logic [AW-1:0] fld, bit hasd, logic [15:0] d, bit ack);
    slot(1'b1, 1'b1, 1'b0, 1'b0, '0, ack);
    for (int b = 1; b >= 0; b--) slot(1'b1, opc[b], 1'b0, 1'b0, '0, 1'b0);
    for (int b = AW - 1; b >= 0; b--) slot(1'b1, fld[b], 1'b0, 1'b0, '0, 1'b0);
    if (hasd) for (int b = 15; b >= 0; b--) slot(1'b1, d[b], 1'b0, 1'b0, '0, 1'b0);
  endtask

  function automatic logic [AW-1:0] ext(logic [1:0] c);
    return {c, {(AW-2){1'b0}}};
  endfunction

  task automatic poll(int ready_after, int lim, inout bit e);
    int lim_e = (lim == 0) ? 1 : lim;
    int n = 0;
    gap(1'b0, '0);
    while (1) begin
      if (n == ready_after) begin slot(1'b1, 1'b0, 1'b1, 1'b0, '0, 1'b0); break; end
      slot(1'b1, 1'b0, 1'b0, 1'b0, '0, 1'b0);
      n++;
      if (n >= lim_e) begin e = 1'b1; break; end
    end
    gap(1'b0, '0);
  endtask

  task automatic run(int cmd, int addr, int cnt, int ra, int plim, int lo, int hi, string tag);
    bit prog  = cmd inside {1, 4, 5, 6};
    bit multi = cmd inside {0, 1, 4};
    int n = multi ? ((cnt == 0) ? 1 : cnt) : 1;
    bit e = 1'b0;
    cyc_t dn;
    @(negedge clk);
    cur_tag = tag;
    widx = 0;
    req_wdata = (wq.size() > 0) ? wq[0] : 16'h0;
    req_cmd = 3'(cmd); req_addr = AW'(addr); req_count = 8'(cnt);
    sck_lo = 8'(lo); sck_hi = 8'(hi); poll_limit = 16'(plim);
    req_valid = 1'b1;
    @(posedge clk);
    lo_e = (lo == 0) ? 1 : lo;
    hi_e = (hi == 0) ? 1 : hi;
    if (prog) begin frame(2'b00, ext(2'b11), 1'b0, '0, 1'b0); gap(1'b0, '0); end
    for (int i = 0; i < n && !e; i++) begin
      logic [AW-1:0] a = AW'(addr + i);
      case (cmd)
        0: begin
          frame(2'b10, a, 1'b0, '0, 1'b0);
          for (int k = 0; k <= 16; k++)
            slot(1'b1, 1'b0, (k == 0) ? 1'b0 : mem[a][16-k], 1'b0, '0, 1'b0);
          gap(1'b1, mem[a]);
        end
        1: begin frame(2'b01, a, 1'b1, wq[i], 1'b1); poll(ra, plim, e); end
        4: begin frame(2'b11, a, 1'b0, '0, 1'b0); poll(ra, plim, e); end
        5: begin frame(2'b00, ext(2'b10), 1'b0, '0, 1'b0); poll(ra, plim, e); end
        6: begin frame(2'b00, ext(2'b01), 1'b1, wq[0], 1'b1); poll(ra, plim, e); end
        2: begin frame(2'b00, ext(2'b11), 1'b0, '0, 1'b0); gap(1'b0, '0); end
        default: begin frame(2'b00, ext(2'b00), 1'b0, '0, 1'b0); gap(1'b0, '0); end
      endcase
    end
    if (prog) begin frame(2'b00, ext(2'b00), 1'b0, '0, 1'b0); gap(1'b0, '0); end
    dn = '0; dn.done = 1'b1; dn.rdy = 1'b1; dn.err = e;
    exp_q.push_back(dn);
    @(negedge clk);
    req_valid = 1'b0;
    wait (exp_q.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog run did not finish");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 16'(16'hA5C3 ^ (i * 16'h0F1B));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(cs === 1'b0 && sck === 1'b0 && dout === 1'b0, "R12", "pins", {cs, sck, dout}, 0);
    chk(req_ready === 1'b1 && done === 1'b0 && rd_valid === 1'b0, "R12", "flags",
        {req_ready, done, rd_valid}, 3'b100);
    chk_on = 1'b1;
    run(2, 0, 1, 0, 0, 1, 1, "R2/R8");
    run(0, 5, 1, 0, 0, 2, 1, "R1/R3");
    run(0, 62, 3, 0, 0, 1, 2, "R10");
    run(0, 9, 0, 0, 0, 1, 1, "R10");
    wq = '{16'hBEEF, 16'h0123};
    run(1, 3, 2, 2, 10, 1, 1, "R4/R5/R6");
    run(1, 10, 2, 50, 3, 1, 1, "R7");
    wq = '{16'h8001};
    run(1, 20, 1, 5, 0, 1, 1, "R7");
    run(4, 7, 1, 1, 8, 2, 1, "R1/R6");
    run(5, 0, 4, 0, 8, 1, 1, "R2/R5");
    wq = '{16'h5A5A};
    run(6, 0, 1, 3, 8, 1, 1, "R2/R4");
    run(3, 0, 1, 0, 0, 1, 1, "R2");
    run(7, 0, 1, 0, 0, 1, 1, "R13");
    run(0, 33, 2, 0, 0, 3, 2, "R9");
    run(0, 17, 1, 0, 0, 0, 0, "R9");
    chk_on = 1'b0;
    summary();
  end
endmodule